// File: doc/BRIEF.md
# Dual-Role SPI Controller

This block is a byte-wide SPI engine that can act as the bus master or as a selected slave. A small register port configures it and moves data through it. In master mode it divides the system clock to make SCK. It shifts one byte out on MOSI while it shifts one byte in on MISO. As a slave it follows an external SCK and an active-low select, and it answers on MISO. Three sticky flags drive one interrupt line:

- transfer done
- mode fault
- write collision

The register port takes every access in the cycle it is presented and has no back-pressure: `reg_wr` and `reg_rd` are plain one-cycle strobes. `reg_rdata` is combinational from `reg_addr`. The register map has three addresses:

- Address 0 is control:
  - bit 0 enable
  - bit 1 master
  - bit 2 clock polarity (CPOL)
  - bit 3 clock phase (CPHA)
  - bits 6:4 rate code
- Address 1 is status (read only): bit 0 done, bit 1 mode fault, bit 2 write collision.
- Address 2 is data:
  - A write loads the byte to send. In master mode that write starts a transfer.
  - A read returns the last byte received.

Serial pins are split into input, output and output-enable so that the pads outside the block can be tri-stated.

Top module: `spi_dr_top`

## Requirements
- R1: A transfer is full duplex. After it ends, the done flag (status bit 0) is 1 and a read of address 2 returns the byte sampled on the input line during that same transfer.
- R2: Bytes travel most significant bit first on MOSI and on MISO.
- R3: In master mode one write to address 2 while idle produces exactly 8 SCK periods (16 edges). SCK then rests at the CPOL level.
- R4: Rate code n (control bits 6:4) makes each master SCK half period 2^n system clocks, which divides the clock by 2, 4, 8 … 256.
- R5: With CPHA=0, data is sampled on the leading SCK edge and changed on the trailing edge. With CPHA=1 the roles swap. SCK idles at CPOL. All four combinations exchange bytes correctly.
- R6: If select goes low while the block is an enabled master, the mode-fault flag (status bit 1) sets and control bit 1 clears. SCK and MOSI are no longer driven.
- R7: A write to address 2 during a transfer sets the write-collision flag (status bit 2). The written byte is discarded and the byte in flight finishes unchanged.
- R8: `irq` is the OR of the three flags. The flags clear when status is read and then address 2 is read or written.
- R9: As an enabled slave (control bit 1 = 0), the block shifts only while select is low. It drives MISO only then, sending the byte written to address 2 and capturing MOSI.
- R10: While select is high, a slave ignores SCK toggles: no flag sets and MISO stays undriven.
- R11: After reset, control and status read 0, no output enable is active and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect: clear sequence) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt, OR of the status flags |
| sck_i | input | 1 | SCK from an external master |
| sck_o | output | 1 | Generated SCK |
| sck_oe | output | 1 | SCK drive enable |
| mosi_i | input | 1 | MOSI in slave mode |
| mosi_o | output | 1 | MOSI in master mode |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_i | input | 1 | MISO in master mode |
| miso_o | output | 1 | MISO in slave mode |
| miso_oe | output | 1 | MISO drive enable |
| ss_n_i | input | 1 | Active-low select |

## Verification
The embedded properties cover the following on every cycle:

- A master SCK rests at CPOL whenever no byte is in flight.
- Done only follows an active transfer.
- The outgoing shift register holds still between SCK edges, including during a collided write.
- A mode fault leaves the master bit cleared.
- A busy data write always raises the collision flag.
- The block never drives MOSI and MISO together.

Only the directed scenarios can show the rest:

- bit order
- the exact edge count and half period for a rate code
- the behaviour in each of the four clock modes
- the slave's response to an external master
- the status-then-data clearing sequence

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } ctrl_t;

  typedef struct packed {
    logic wcol;
    logic modf;
    logic done;
  } stat_t;
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_dr_div.sv
module spi_dr_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CW = (1 << RATE_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = CW'((32'd1 << rate) - 32'd1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || tick)    cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_dr_engine.sv
module spi_dr_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic              abort,
  input  logic              sel,
  input  logic              tick,
  input  logic              s_sck,
  input  logic              s_mosi,
  input  logic              miso_i,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              sck_o,
  output logic              ser_o,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [DATA_W-1:0] tx_sr, rx_sr, rx_nxt;
  logic [EW-1:0]     ecnt;
  logic              tgl, sel_q, sck_q;
  logic              ev, samp, shf, last, in_bit, slv_go;

  // edge event: divider tick as master, synchronised SCK change as slave
  assign ev     = busy && (master ? tick : (s_sck != sck_q));
  assign samp   = ev && (ecnt[0] == cpha);
  assign shf    = ev && (ecnt[0] != cpha) && (ecnt != '0);
  assign last   = ev && (ecnt == EW'(EDGES - 1));
  assign in_bit = master ? miso_i : s_mosi;
  assign rx_nxt = {rx_sr[DATA_W-2:0], in_bit};
  assign slv_go = !master && sel && !sel_q;

  assign sck_o = cpol ^ tgl;
  assign ser_o = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tgl     <= 1'b0;
      ecnt    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
      sel_q   <= 1'b0;
      sck_q   <= 1'b0;
    end else begin
      sck_q <= s_sck;
      sel_q <= sel;
      done  <= 1'b0;
      if (abort || (!master && !sel)) begin
        busy <= 1'b0;
        tgl  <= 1'b0;
        ecnt <= '0;
      end else if (!busy && ((master && start) || slv_go)) begin
        busy  <= 1'b1;
        tx_sr <= tx_byte;
        ecnt  <= '0;
        tgl   <= 1'b0;
      end else if (ev) begin
        ecnt <= ecnt + 1'b1;
        if (master) tgl <= ~tgl;
        if (samp)   rx_sr <= rx_nxt;
        if (shf)    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= samp ? rx_nxt : rx_sr;
        end
      end
    end
  end

  // R3: master SCK rests at polarity level between bytes
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> (sck_o == cpol));
  // R1: completion only follows an active transfer
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R7: shift data is frozen between edges, so a collided write cannot touch it
  p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev) |=> $stable(tx_sr));
endmodule

// File: rtl/spi_dr_top.sv
module spi_dr_top
  import spi_dr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = $bits(stat_t);

  ctrl_t             ctrl;
  stat_t             stat;
  logic              armed;
  logic [DATA_W-1:0] tx_hold, rx_byte, tx_byte;
  logic [2:0]        sync_q;
  logic              ss_s, sck_s, mosi_s, sel;
  logic              busy, done_p, tick, ser, eng_sck;
  logic              data_wr, data_rd, stat_rd, clr;
  logic              modf_ev, wcol_ev, start, abort;

  spi_dr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i, mosi_i}), .q(sync_q));
  assign {ss_s, sck_s, mosi_s} = sync_q;
  assign sel = !ss_s;

  assign data_wr = reg_wr && (reg_addr == A_DATA);
  assign data_rd = reg_rd && (reg_addr == A_DATA);
  assign stat_rd = reg_rd && (reg_addr == A_STAT);
  assign clr     = armed && (data_wr || data_rd);
  assign modf_ev = ctrl.en && ctrl.master && sel;
  assign wcol_ev = data_wr && busy;
  assign start   = data_wr && !busy && ctrl.en;
  assign abort   = !ctrl.en || modf_ev;
  assign tx_byte = ctrl.master ? reg_wdata : tx_hold;

  spi_dr_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy && ctrl.master),
    .rate(ctrl.rate), .tick(tick));

  spi_dr_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .master(ctrl.master), .cpol(ctrl.cpol),
    .cpha(ctrl.cpha), .start(start), .abort(abort), .sel(sel), .tick(tick),
    .s_sck(sck_s), .s_mosi(mosi_s), .miso_i(miso_i), .tx_byte(tx_byte),
    .busy(busy), .sck_o(eng_sck), .ser_o(ser), .done(done_p), .rx_byte(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      stat    <= '0;
      armed   <= 1'b0;
      tx_hold <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (modf_ev) ctrl.master <= 1'b0;
      if (data_wr && !busy) tx_hold <= reg_wdata;
      if (stat_rd)                 armed <= 1'b1;
      else if (data_wr || data_rd) armed <= 1'b0;
      stat.done <= done_p  || (stat.done && !clr);
      stat.modf <= modf_ev || (stat.modf && !clr);
      stat.wcol <= wcol_ev || (stat.wcol && !clr);
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl);
      A_STAT:  reg_rdata = DATA_W'(stat);
      A_DATA:  reg_rdata = rx_byte;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = |stat[STAT_W-1:0];
  assign sck_o   = eng_sck;
  assign sck_oe  = ctrl.en && ctrl.master;
  assign mosi_o  = ser;
  assign mosi_oe = ctrl.en && ctrl.master;
  assign miso_o  = ser;
  assign miso_oe = ctrl.en && !ctrl.master && sel;

  // R6: a fault always leaves the block out of the master role
  p_modf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.modf) |-> !ctrl.master);
  // R7: a busy data write raises the collision flag
  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> stat.wcol);
  // R9: the two data outputs are never driven together
  p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !mosi_oe);
endmodule

// File: tb/tb_spi_dr_top.sv
module tb_spi_dr_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq, sck_i = 1'b0, sck_o, sck_oe, mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe, ss_n_i = 1'b1;

  int n_chk = 0, n_err = 0;

  logic [7:0] bm_tx = '0, bm_rx = '0;
  int         bm_edges = 0;
  logic       bm_on = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0;
  realtime    last_t = 0, half_meas = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso_i = bm_tx[7];

  spi_dr_top dut (.*);

  // bench-side slave model for master tests
  always @(sck_o) begin
    if (sck_oe && bm_on) begin
      if ((sck_o != b_cpol) ^ b_cpha) bm_rx = {bm_rx[6:0], mosi_o};
      else if (bm_edges != 0)          bm_tx = {bm_tx[6:0], 1'b0};
      half_meas = $realtime - last_t;
      last_t    = $realtime;
      bm_edges++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 sck_oe", sck_oe, 0);
    chk("R11 miso_oe", miso_oe, 0);
    chk("R11 irq", irq, 0);
    rd(2'd0, v); chk("R11 ctrl", v, 0);
    rd(2'd1, v); chk("R11 status", v, 0);
  endtask

  task automatic t_master(input logic cpol, input logic cpha, input int rate,
                          input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] v;
    wr(2'd0, {1'b0, 3'(rate), cpha, cpol, 1'b1, 1'b1});
    b_cpol = cpol; b_cpha = cpha; bm_tx = stx; bm_rx = '0; bm_edges = 0;
    last_t = $realtime; bm_on = 1'b1;
    wr(2'd2, tx);
    wait (bm_edges == 16);
    repeat (3) @(negedge clk);
    bm_on = 1'b0;
    chk("R2 MOSI byte MSB first", bm_rx, tx);
    chk("R3 sixteen SCK edges", bm_edges, 16);
    chk("R3/R5 SCK idle at CPOL", sck_o, cpol);
    chk("R4 half period", int'(half_meas), (1 << rate) * CLK_PERIOD);
    chk("R8 irq on done", irq, 1);
    rd(2'd1, v); chk("R1 done flag", v, 8'h01);
    rd(2'd2, v); chk("R1/R5 received byte", v, stx);
    rd(2'd1, v); chk("R8 flags cleared", v, 8'h00);
  endtask

  task automatic t_wcol();
    logic [7:0] v;
    wr(2'd0, {1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1});
    b_cpol = 0; b_cpha = 0; bm_tx = 8'h00; bm_rx = '0; bm_edges = 0; bm_on = 1'b1;
    wr(2'd2, 8'h96);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h11);
    wait (bm_edges == 16);
    repeat (3) @(negedge clk);
    bm_on = 1'b0;
    chk("R7 byte in flight unchanged", bm_rx, 8'h96);
    rd(2'd1, v); chk("R7 collision and done", v, 8'h05);
    rd(2'd2, v);
    rd(2'd1, v); chk("R8 cleared after collision", v, 8'h00);
  endtask

  task automatic t_modf();
    logic [7:0] v;
    wr(2'd0, 8'h03);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 sck released", sck_oe, 0);
    chk("R6 mosi released", mosi_oe, 0);
    chk("R8 irq on fault", irq, 1);
    rd(2'd1, v); chk("R6 fault flag", v, 8'h02);
    rd(2'd0, v); chk("R6 master bit cleared", v, 8'h01);
    ss_n_i = 1'b1;
    rd(2'd1, v); rd(2'd2, v);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_slave(input logic cpol, input logic cpha,
                         input logic [7:0] mb, input logic [7:0] stx);
    logic [7:0] v, got;
    got = '0;
    sck_i = cpol; ss_n_i = 1'b1;
    wr(2'd0, {1'b0, 3'd0, cpha, cpol, 1'b0, 1'b1});
    wr(2'd2, stx);
    repeat (4) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (H) @(negedge clk);
    chk("R9 MISO driven when selected", miso_oe, 1);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = mb[i]; sck_i = ~sck_i; got = {got[6:0], miso_o};
        repeat (H) @(negedge clk);
        sck_i = ~sck_i;
        repeat (H) @(negedge clk);
      end else begin
        sck_i = ~sck_i; mosi_i = mb[i];
        repeat (H) @(negedge clk);
        sck_i = ~sck_i; got = {got[6:0], miso_o};
        repeat (H) @(negedge clk);
      end
    end
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 MISO released", miso_oe, 0);
    chk("R2/R9 MISO byte", got, stx);
    rd(2'd1, v); chk("R9 slave done", v, 8'h01);
    rd(2'd2, v); chk("R9 slave received", v, mb);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    sck_i = 1'b0; ss_n_i = 1'b1;
    wr(2'd0, 8'h01);
    for (int i = 0; i < 16; i++) begin
      sck_i = ~sck_i; mosi_i = i[0];
      repeat (4) @(negedge clk);
      if (miso_oe !== 1'b0) chk("R10 MISO undriven", miso_oe, 0);
    end
    rd(2'd1, v); chk("R10 no transfer while deselected", v, 8'h00);
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master(1'b0, 1'b0, 0, 8'hA5, 8'h3C);
    t_master(1'b0, 1'b1, 1, 8'h5A, 8'hC3);
    t_master(1'b1, 1'b0, 3, 8'h81, 8'h7E);
    t_master(1'b1, 1'b1, 2, 8'h0F, 8'hF0);
    t_master(1'b0, 1'b0, 7, 8'h01, 8'h80);
    t_wcol();
    t_modf();
    t_slave(1'b0, 1'b0, 8'hB4, 8'h6D);
    t_slave(1'b1, 1'b1, 8'h29, 8'hD2);
    t_slave(1'b0, 1'b1, 8'hE1, 8'h1E);
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule